// File: doc/BRIEF.md
# Fragmented Pipeline Flow Controller

This block owns the program counter and every instruction latch of a small in-order pipeline whose middle is split into four parallel paths. A single decode latch feeds an integer execute latch, a three-latch multiplier chain, a two-latch adder chain and a multicycle divider latch. All four paths rejoin at one writeback latch. Every cycle the block decides, for each latch, whether it takes normal flow, stalls or is filled with a nop. It also decides how the program counter moves.

Instructions are opaque tags. The only field the block reads is a unit-select field in the low bits of the word. Stall requests travel backwards through the latch tree. A latch stalls on its own hazard request or because of the latch or latches after it. Decode only stalls outright when all four of its child latches are stalled, or when the one child its instruction needs cannot accept. Results leave for writeback strictly in issue order, one per cycle. A path whose result is not the oldest is held back.

Top module: `pipe_flow_ctl`

## Requirements
- R1: A synchronous active-high reset clears every latch to a nop (lat_vld all zero) and sets pc to zero.
- R2: Each latch reports exactly one flow state per cycle, encoded 2 bits at lat_state[2i+1:2i]. 0 is normal flow, 1 is stall and 2 is nop insertion. On stall the latch keeps its valid bit and word. On nop insertion it becomes invalid. On normal flow it loads its parent's word. Latch index order is: 0 decode, 1 execute, 2 to 4 multiplier stages one to three, 5 and 6 adder stages one and two, 7 divider, 8 writeback.
- R3: pc_state 0 means the pc advances by 4, 1 means it loads br_target, and 2 means it holds. It holds whenever decode stalls or fetch_vld is low. Otherwise a high br_taken selects the target.
- R4: When decode is not stalled it loads fetch_word if fetch_vld is high and inserts a nop otherwise. Decode stalls when all four first-level unit latches (1, 2, 5, 7) stall, and also when its valid instruction's target unit latch stalls.
- R5: A valid latch whose haz_req bit is high stalls. A hazard request on a latch that holds a nop does not stall that latch.
- R6: Inside the multiplier and adder chains, a stalled later latch stalls the latch before it.
- R7: Bits [1:0] of a word select its unit: 0 execute, 1 multiplier, 2 adder, 3 divider. A first-level unit latch takes normal flow exactly when decode hands over a valid instruction for that unit.
- R8: A valid decode instruction for any unit other than the multiplier does not leave decode while multiplier stage one or two holds a valid instruction.
- R9: An instruction stays in the divider latch for at least 4 cycles.
- R10: Writeback receives at most one instruction per cycle. Instructions reach it in exactly the order decode accepted them, with none lost or duplicated.
- R11: With hazards and fetch removed, every in-flight instruction drains and all latches become nops within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Fetched word is present |
| fetch_word | input | W | Fetched instruction tag; bits [1:0] select the unit |
| br_taken | input | 1 | Branch taken this cycle |
| br_target | input | PC_W | Branch target address |
| haz_req | input | 9 | Per-latch local hazard stall requests |
| pc | output | PC_W | Program counter |
| pc_state | output | 2 | Program counter action this cycle |
| lat_vld | output | 9 | Per-latch valid bit (0 = nop) |
| lat_word | output | 9*W | Per-latch word, latch i at [i*W +: W] |
| lat_state | output | 18 | Per-latch flow state, 2 bits each |

## Verification
A wrong stall decision shows up on the first clock edge after it is made. A latch that should have held instead changes its word, or a latch reported as flowing fails to carry its parent's word. The bench compares each latch with its parent one cycle back. A wrong sequence tag or a wrong writeback choice is quieter. It shows only when that instruction reaches writeback, where the word arriving no longer matches the head of the issue-order queue. Depending on the path, that can be several cycles after the error. A divider count that is too short is caught when the instruction leaves the divider with fewer than four cycles spent there.

// File: rtl/pipe_flow_ctl.sv
module pipe_flow_ctl #(
  parameter int W       = 8,
  parameter int PC_W    = 16,
  parameter int PC_STEP = 4,
  parameter int SEQ_W   = 4,
  parameter int DIV_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_vld,
  input  logic [W-1:0]      fetch_word,
  input  logic              br_taken,
  input  logic [PC_W-1:0]   br_target,
  input  logic [8:0]        haz_req,
  output logic [PC_W-1:0]   pc,
  output logic [1:0]        pc_state,
  output logic [8:0]        lat_vld,
  output logic [9*W-1:0]    lat_word,
  output logic [17:0]       lat_state
);
  localparam int N   = 9;
  localparam int DEC = 0, EX = 1, M1 = 2, M2 = 3, M3 = 4, A1 = 5, A2 = 6, DV = 7, WB = 8;
  localparam int CW  = $clog2(DIV_LAT + 1);
  localparam logic [1:0] FS_NF = 2'd0, FS_ST = 2'd1, FS_NI = 2'd2;
  localparam logic [1:0] PS_SEQ = 2'd0, PS_BR = 2'd1, PS_ST = 2'd2;
  localparam logic [1:0] U_EX = 2'd0, U_MUL = 2'd1, U_ADD = 2'd2, U_DIV = 2'd3;

  logic [N-1:0]     vld, stl, nf, self_st;
  logic [W-1:0]     wrd [N];
  logic [W-1:0]     sw  [N];
  logic [SEQ_W-1:0] sq  [N-1];
  logic [SEQ_W-1:0] ss  [N-1];
  logic [SEQ_W-1:0] iseq, rseq;
  logic [CW-1:0]    dcnt;
  logic [1:0]       tgt;
  logic             c_ex, c_m, c_a, c_d, tst, ordblk, dgo;

  assign tgt = wrd[DEC][1:0];

  always_comb begin
    self_st     = vld & haz_req;
    self_st[DV] = vld[DV] & (haz_req[DV] | (dcnt != '0));

    c_ex = vld[EX] & ~self_st[EX] & (sq[EX] == rseq);
    c_m  = vld[M3] & ~self_st[M3] & (sq[M3] == rseq);
    c_a  = vld[A2] & ~self_st[A2] & (sq[A2] == rseq);
    c_d  = vld[DV] & ~self_st[DV] & (sq[DV] == rseq);

    stl      = '0;
    stl[WB]  = self_st[WB];
    stl[EX]  = self_st[EX] | stl[WB] | (vld[EX] & ~c_ex);
    stl[M3]  = self_st[M3] | stl[WB] | (vld[M3] & ~c_m);
    stl[A2]  = self_st[A2] | stl[WB] | (vld[A2] & ~c_a);
    stl[DV]  = self_st[DV] | stl[WB] | (vld[DV] & ~c_d);
    stl[M2]  = self_st[M2] | stl[M3];
    stl[M1]  = self_st[M1] | stl[M2];
    stl[A1]  = self_st[A1] | stl[A2];

    case (tgt)
      U_EX:    tst = stl[EX];
      U_MUL:   tst = stl[M1];
      U_ADD:   tst = stl[A1];
      default: tst = stl[DV];
    endcase
    ordblk   = vld[DEC] & (tgt != U_MUL) & (vld[M1] | vld[M2]);
    stl[DEC] = self_st[DEC] | (vld[DEC] & (tst | ordblk))
             | (stl[EX] & stl[M1] & stl[A1] & stl[DV]);
    dgo      = vld[DEC] & ~stl[DEC];

    for (int i = 0; i < N; i++) sw[i] = '0;
    for (int i = 0; i < N-1; i++) ss[i] = '0;
    nf = '0;

    nf[DEC] = ~stl[DEC] & fetch_vld;
    sw[DEC] = fetch_word;
    ss[DEC] = iseq;

    nf[EX] = ~stl[EX] & dgo & (tgt == U_EX);
    nf[M1] = ~stl[M1] & dgo & (tgt == U_MUL);
    nf[A1] = ~stl[A1] & dgo & (tgt == U_ADD);
    nf[DV] = ~stl[DV] & dgo & (tgt == U_DIV);
    sw[EX] = wrd[DEC]; ss[EX] = sq[DEC];
    sw[M1] = wrd[DEC]; ss[M1] = sq[DEC];
    sw[A1] = wrd[DEC]; ss[A1] = sq[DEC];
    sw[DV] = wrd[DEC]; ss[DV] = sq[DEC];

    nf[M2] = ~stl[M2] & vld[M1] & ~stl[M1];
    sw[M2] = wrd[M1]; ss[M2] = sq[M1];
    nf[M3] = ~stl[M3] & vld[M2] & ~stl[M2];
    sw[M3] = wrd[M2]; ss[M3] = sq[M2];
    nf[A2] = ~stl[A2] & vld[A1] & ~stl[A1];
    sw[A2] = wrd[A1]; ss[A2] = sq[A1];

    nf[WB] = ~stl[WB] & (c_ex | c_m | c_a | c_d);
    if (c_ex)     sw[WB] = wrd[EX];
    else if (c_m) sw[WB] = wrd[M3];
    else if (c_a) sw[WB] = wrd[A2];
    else          sw[WB] = wrd[DV];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      for (int i = 0; i < N; i++) wrd[i] <= '0;
      for (int i = 0; i < N-1; i++) sq[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (nf[i]) begin
          vld[i] <= 1'b1;
          wrd[i] <= sw[i];
        end else if (!stl[i]) begin
          vld[i] <= 1'b0;
          wrd[i] <= '0;
        end
      end
      for (int i = 0; i < N-1; i++) begin
        if (nf[i])        sq[i] <= ss[i];
        else if (!stl[i]) sq[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iseq <= '0;
      rseq <= '0;
      dcnt <= '0;
    end else begin
      if (nf[DEC]) iseq <= iseq + SEQ_W'(1);
      if (nf[WB])  rseq <= rseq + SEQ_W'(1);
      if (nf[DV])                      dcnt <= CW'(DIV_LAT - 1);
      else if (vld[DV] && dcnt != '0)  dcnt <= dcnt - CW'(1);
    end
  end

  assign pc_state = (stl[DEC] | ~fetch_vld) ? PS_ST : (br_taken ? PS_BR : PS_SEQ);

  always_ff @(posedge clk) begin
    if (rst)                  pc <= '0;
    else if (pc_state == PS_BR)  pc <= br_target;
    else if (pc_state == PS_SEQ) pc <= pc + PC_W'(PC_STEP);
  end

  assign lat_vld = vld;
  for (genvar g = 0; g < N; g++) begin : g_out
    assign lat_word[g*W +: W]    = wrd[g];
    assign lat_state[2*g +: 2]   = stl[g] ? FS_ST : (nf[g] ? FS_NF : FS_NI);
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (vld == '0 && pc == '0));

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stl[DEC] |=> pc == $past(pc));

  // R5
  self_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vld[EX] && haz_req[EX]) |=> (vld[EX] && wrd[EX] == $past(wrd[EX])));

  // R8
  mul_order_chk: assert property (@(posedge clk) disable iff (rst)
    (vld[DEC] && tgt != U_MUL && (vld[M1] || vld[M2])) |-> !(nf[EX] || nf[A1] || nf[DV]));

  // R9
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vld[DV] && dcnt != '0) |=> (vld[DV] && wrd[DV] == $past(wrd[DV])));

  // R10
  wb_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({c_ex, c_m, c_a, c_d}));
endmodule

// File: tb/pipe_flow_ctl_tb.sv
`timescale 1ns/100ps
module pipe_flow_ctl_tb_top;
  localparam int W = 8, PC_W = 16, N = 9;
  localparam int DEC = 0, EX = 1, M1 = 2, M2 = 3, M3 = 4, A1 = 5, A2 = 6, DV = 7, WB = 8;
  localparam logic [1:0] NF = 2'd0, ST = 2'd1, NI = 2'd2;
  localparam logic [1:0] P_SEQ = 2'd0, P_BR = 2'd1, P_ST = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_vld = 1'b0, br_taken = 1'b0;
  logic [W-1:0] fetch_word = '0;
  logic [PC_W-1:0] br_target = '0;
  logic [8:0] haz_req = '0;
  logic [PC_W-1:0] pc;
  logic [1:0] pc_state;
  logic [8:0] lat_vld;
  logic [9*W-1:0] lat_word;
  logic [17:0] lat_state;

  pipe_flow_ctl #(.W(W), .PC_W(PC_W)) dut_i (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_word(fetch_word),
    .br_taken(br_taken), .br_target(br_target), .haz_req(haz_req),
    .pc(pc), .pc_state(pc_state), .lat_vld(lat_vld), .lat_word(lat_word),
    .lat_state(lat_state));

  always #2 clk = ~clk;

  int errs = 0, checks = 0, dres = 0;
  logic [5:0] next_id = '0;
  logic [W-1:0] q[$];
  logic [8:0] p_vld;
  logic [9*W-1:0] p_word;
  logic [17:0] p_st;
  logic [PC_W-1:0] p_pc;
  logic [1:0] p_pcs;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] sto(input logic [17:0] s, input int i);
    return s[2*i +: 2];
  endfunction
  function automatic logic [W-1:0] wo(input logic [9*W-1:0] v, input int i);
    return v[i*W +: W];
  endfunction
  function automatic int parent(input int i);
    case (i)
      M2: return M1;
      M3: return M2;
      A2: return A1;
      default: return DEC;
    endcase
  endfunction
  function automatic logic [1:0] unit_of(input int i);
    case (i)
      EX: return 2'd0;
      M1: return 2'd1;
      A1: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  task automatic tick();
    logic [1:0] exp_pcs;
    @(negedge clk);
    p_vld = lat_vld; p_word = lat_word; p_st = lat_state; p_pc = pc; p_pcs = pc_state;
    for (int i = 0; i < N; i++)
      chk(sto(p_st, i) != 2'd3, "R2 state code", sto(p_st, i), 0);
    exp_pcs = (sto(p_st, DEC) == ST || !fetch_vld) ? P_ST : (br_taken ? P_BR : P_SEQ);
    chk(p_pcs == exp_pcs, "R3 pc_state", p_pcs, exp_pcs);
    if (sto(p_st, DEC) != ST)
      chk(sto(p_st, DEC) == (fetch_vld ? NF : NI), "R4 decode fill", sto(p_st, DEC), fetch_vld ? NF : NI);
    if (sto(p_st, EX) == ST && sto(p_st, M1) == ST && sto(p_st, A1) == ST && sto(p_st, DV) == ST)
      chk(sto(p_st, DEC) == ST, "R4 all children stalled", sto(p_st, DEC), ST);
    if (p_vld[DEC]) begin
      int t;
      case (wo(p_word, DEC)[1:0])
        2'd0: t = EX; 2'd1: t = M1; 2'd2: t = A1; default: t = DV;
      endcase
      if (sto(p_st, t) == ST) chk(sto(p_st, DEC) == ST, "R4 target stalled", sto(p_st, DEC), ST);
      if (wo(p_word, DEC)[1:0] != 2'd1 && (p_vld[M1] || p_vld[M2]))
        chk(sto(p_st, DEC) == ST, "R8 mul order", sto(p_st, DEC), ST);
    end
    for (int i = 0; i < N; i++)
      if (p_vld[i] && haz_req[i]) chk(sto(p_st, i) == ST, "R5 self hazard", sto(p_st, i), ST);
    for (int i = M1; i <= A1; i++) begin
      if (i == M3) continue;
      if (sto(p_st, i + 1) == ST) chk(sto(p_st, i) == ST, "R6 child stall", sto(p_st, i), ST);
      else if (!p_vld[i] && haz_req[i]) chk(sto(p_st, i) != ST, "R5 nop ignores hazard", sto(p_st, i), NF);
    end
    for (int i = EX; i < N; i++) begin
      if (i == EX || i == M1 || i == A1 || i == DV) begin
        bit go = p_vld[DEC] && sto(p_st, DEC) != ST && wo(p_word, DEC)[1:0] == unit_of(i);
        chk((sto(p_st, i) == NF) == go, "R7 unit select", sto(p_st, i), go ? NF : 2'd3);
      end
    end
    if (p_vld[DV] && sto(p_st, DV) != ST) chk(dres >= 4, "R9 divider occupancy", dres, 4);
    if (sto(p_st, DEC) == NF) q.push_back(fetch_word);
    @(posedge clk);
    #0.5;
    for (int i = 0; i < N; i++) begin
      logic [1:0] s = sto(p_st, i);
      if (s == ST) begin
        chk(lat_vld[i] == p_vld[i] && wo(lat_word, i) == wo(p_word, i), "R2 stall keeps", wo(lat_word, i), wo(p_word, i));
      end else if (s == NI) begin
        chk(!lat_vld[i], "R2 nop insert", lat_vld[i], 0);
      end else if (i == DEC) begin
        chk(lat_vld[i] && wo(lat_word, i) == wo(q[$], 0), "R4 decode load", wo(lat_word, i), q[$]);
      end else if (i != WB) begin
        int p = parent(i);
        chk(lat_vld[i] && wo(lat_word, i) == wo(p_word, p), "R2 flow load", wo(lat_word, i), wo(p_word, p));
      end
    end
    if (sto(p_st, WB) == NF) begin
      if (q.size() > 1 || (q.size() == 1 && sto(p_st, DEC) != NF)) begin
        chk(lat_vld[WB] && wo(lat_word, WB) == q[0], "R10 writeback order", wo(lat_word, WB), q[0]);
        void'(q.pop_front());
      end else chk(1'b0, "R10 writeback without issue", wo(lat_word, WB), 0);
    end
    case (p_pcs)
      P_ST:  chk(pc == p_pc, "R3 pc hold", pc, p_pc);
      P_BR:  chk(pc == br_target, "R3 pc branch", pc, br_target);
      default: chk(pc == p_pc + 16'd4, "R3 pc step", pc, p_pc + 16'd4);
    endcase
    if (sto(p_st, DV) == NF) dres = 1;
    else if (sto(p_st, DV) == ST && lat_vld[DV]) dres++;
  endtask

  task automatic set_in(input bit fv, input logic [1:0] u, input bit br, input logic [8:0] hz);
    fetch_vld  = fv;
    fetch_word = {next_id, u};
    br_taken   = br;
    br_target  = PC_W'($urandom) & 16'hfffc;
    haz_req    = hz;
  endtask

  task automatic adv_id();
    if (p_st[1:0] == NF) next_id = next_id + 6'd1;
  endtask

  task automatic run_rand(input int cycles, input int hz_pct);
    for (int c = 0; c < cycles; c++) begin
      logic [8:0] hz;
      for (int b = 0; b < N; b++) hz[b] = ($urandom % 100) < hz_pct;
      set_in(($urandom % 10) < 8, 2'($urandom), ($urandom % 8) == 0, hz);
      tick();
      adv_id();
    end
  endtask

  task automatic drain();
    for (int c = 0; c < 60; c++) begin
      set_in(1'b0, 2'd0, 1'b0, '0);
      tick();
    end
    chk(lat_vld == '0, "R11 drained", lat_vld, 0);
    chk(q.size() == 0, "R11 nothing lost", q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #0.5;
    chk(lat_vld == '0, "R1 latches cleared", lat_vld, 0);
    chk(pc == '0, "R1 pc cleared", pc, 0);
    rst = 1'b0;
    // R5: hazard on empty multiplier stage one with nothing behind it
    set_in(1'b0, 2'd0, 1'b0, 9'b0_0000_0100);
    tick();
    // R8 R9 R10: multiply, add, execute, divide, divide, multiply
    begin
      logic [1:0] seq_u [6] = '{2'd1, 2'd2, 2'd0, 2'd3, 2'd3, 2'd1};
      for (int k = 0; k < 6; k++) begin
        set_in(1'b1, seq_u[k], 1'b0, '0);
        tick();
        adv_id();
        while (p_st[1:0] == ST) begin
          set_in(1'b1, seq_u[k], 1'b0, '0);
          tick();
          adv_id();
        end
      end
    end
    drain();
    // R3: taken branch with clear pipeline
    set_in(1'b1, 2'd0, 1'b1, '0);
    tick();
    adv_id();
    drain();
    // R4: writeback hazard backs everything up until decode stalls
    for (int c = 0; c < 20; c++) begin
      set_in(1'b1, 2'($urandom), 1'b0, 9'b1_0000_0000);
      tick();
      adv_id();
    end
    drain();
    run_rand(1500, 12);
    drain();
    run_rand(1500, 35);
    drain();
    run_rand(1500, 0);
    drain();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule